// File: doc/BRIEF.md
# Flash Access Protection Unit

This block sits between the CPU and an on-chip flash controller and decides, one request at a time, whether an access may go through. It covers two flash regions: a 256 KB program region starting at address 0, and an 8 KB data region at 0x0E0000 to 0x0E1FFF. Any other address is passed on tagged as not-flash, with no permission check.

CPU reads are always granted. A CPU write to flash goes through only if three conditions hold. It must not fall in the boot area. Its section must be write-enabled. The global write-protect field must leave writes open. The boot area runs from address 0 up to a programmable end address, which is capped at 0x001BFF. Section write enables are held in software-writable registers behind a small register bus. Program flash uses 8 KB sections and data flash uses 512-byte sections.

A separate external read port serves a debugger or flash programmer. Reads on that port are blocked by a global read-protect field. Both protect fields are 3 bits wide and are decoded by majority vote. Refused accesses are dropped and raise one-cycle violation pulses.

Top module: `flash_guard`

## Requirements
- R1: An address below 0x040000 is region code 1 (program). An address from 0x0E0000 to 0x0E1FFF is region code 2 (data). Any other address is region code 0 (not-flash). The code is reported on `grant_region`.
- R2: The boot area spans program addresses from 0 up to and including the effective end. The effective end equals `boot_end`, or 0x001BFF when `boot_end` is larger than that.
- R3: A CPU write into the boot area is always refused, whatever the section enables and the protect field hold.
- R4: The enable registers are selected by `reg_sel`. Code 0 holds program sections 0-15 and code 1 holds program sections 16-31; the program section number is address bits [17:13]. Code 2 holds data sections 0-15; the data section number is address bits [12:9]. Bit n of a register enables section n within that register's group. A register write updates it on the clock edge. `reg_rdata` shows the selected register combinationally. Code 3 reads as zero, and writes to code 3 change no register.
- R5: Reset clears every section enable bit, and clears both grant outputs and both violation outputs.
- R6: A CPU write to flash outside the boot area is granted only when its section bit is 1 and global write protection is off.
- R7: Global write protection is on when at least two of the three `prot_wr` bits are 0.
- R8: External read protection is on when at least two of the three `prot_rd` bits are 0. One cycle after `ext_rd_req`, `ext_rd_ack` is 1. At that point `ext_rd_dout` is zero and `ext_rd_viol` is 1 if protection is on; otherwise `ext_rd_dout` carries `ext_rd_din` and `ext_rd_viol` is 0.
- R9: CPU reads are granted in every region, regardless of `prot_rd`, `prot_wr` and the enables.
- R10: Grant and violation outputs appear one cycle after the request and last one cycle. A refused write gives `wr_viol`=1 with `grant_vld`=0. A granted request gives `grant_vld`=1 together with its address and write flag.
- R11: A not-flash request is always granted, with region code 0 and no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_vld | input | 1 | CPU request valid |
| cpu_we | input | 1 | CPU request is a write |
| cpu_addr | input | ADDR_W | CPU byte address |
| boot_end | input | ADDR_W | Programmable last address of the boot area |
| prot_wr | input | VOTE_W | Global write-protect field |
| prot_rd | input | VOTE_W | Global external-read-protect field |
| reg_wr | input | 1 | Enable register write strobe |
| reg_sel | input | SEL_W | Enable register select |
| reg_wdata | input | REG_W | Enable register write data |
| reg_rdata | output | REG_W | Selected enable register contents |
| ext_rd_req | input | 1 | External read request |
| ext_rd_din | input | DATA_W | Data read from flash for the external port |
| grant_vld | output | 1 | Request forwarded to the flash controller |
| grant_we | output | 1 | Forwarded request is a write |
| grant_addr | output | ADDR_W | Forwarded address |
| grant_region | output | 2 | Region code of the forwarded request |
| wr_viol | output | 1 | Refused CPU write pulse |
| ext_rd_ack | output | 1 | External read result valid |
| ext_rd_dout | output | DATA_W | External read data, zero when blocked |
| ext_rd_viol | output | 1 | Refused external read pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit enable registers, 32 program sections and 16 data sections, and a boot cap of 0x001BFF. With these values every section bit is a single register bit, and all three register codes plus the unused fourth can be reached. Boot end values drawn above the cap exercise the clamp. Addresses are drawn from near the boot boundary, from the edges of both regions, and from just outside them, so every region code and the write decision for each section are covered.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_PROG = 2'd1,
    RGN_DATA = 2'd2
  } region_e;
endpackage

// File: rtl/fg_addr_decode.sv
module fg_addr_decode
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PROG_LOG2  = 18,
  parameter int PSECT_LOG2 = 13,
  parameter int DATA_LOG2  = 13,
  parameter int DSECT_LOG2 = 9,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'h0E0000,
  parameter logic [ADDR_W-1:0] BOOT_MAX  = 24'h001BFF,
  localparam int PS_W = PROG_LOG2 - PSECT_LOG2,
  localparam int DS_W = DATA_LOG2 - DSECT_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] boot_end,
  output region_e           region,
  output logic              in_boot,
  output logic [PS_W-1:0]   psect,
  output logic [DS_W-1:0]   dsect
);
  logic              prog_hit;
  logic              data_hit;
  logic [ADDR_W-1:0] boot_eff;

  always_comb begin
    prog_hit = (addr[ADDR_W-1:PROG_LOG2] == '0);
    data_hit = (addr[ADDR_W-1:DATA_LOG2] == DATA_BASE[ADDR_W-1:DATA_LOG2]);
    boot_eff = (boot_end > BOOT_MAX) ? BOOT_MAX : boot_end;
    if (prog_hit)      region = RGN_PROG;
    else if (data_hit) region = RGN_DATA;
    else               region = RGN_NONE;
    in_boot = prog_hit && (addr <= boot_eff);
    psect   = addr[PROG_LOG2-1:PSECT_LOG2];
    dsect   = addr[DATA_LOG2-1:DSECT_LOG2];
  end
endmodule

// File: rtl/fg_vote.sv
module fg_vote #(
  parameter int W = 3,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0] bits,
  output logic         active
);
  logic [CNT_W-1:0] zeros;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      zeros = zeros + CNT_W'(!bits[i]);
    end
    active = (zeros > CNT_W'(W / 2));
  end
endmodule

// File: rtl/fg_sect_regs.sv
module fg_sect_regs #(
  parameter int REG_W  = 16,
  parameter int N_PROG = 32,
  parameter int N_DATA = 16,
  localparam int N_PREG = N_PROG / REG_W,
  localparam int N_DREG = N_DATA / REG_W,
  localparam int N_REG  = N_PREG + N_DREG,
  localparam int SEL_W  = $clog2(N_REG + 1),
  localparam int PI_W   = $clog2(N_PROG),
  localparam int DI_W   = $clog2(N_DATA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [PI_W-1:0]  pidx,
  input  logic [DI_W-1:0]  didx,
  output logic             pen,
  output logic             den
);
  logic [N_REG*REG_W-1:0] all_bits;
  logic [N_PROG-1:0]      prog_bits;
  logic [N_DATA-1:0]      data_bits;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic             load;
    logic [REG_W-1:0] d;
    logic [REG_W-1:0] q;

    always_comb begin
      load = reg_wr && (reg_sel == SEL_W'(g));
      d    = load ? reg_wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
    end

    assign all_bits[g*REG_W +: REG_W] = q;
  end

  assign prog_bits = all_bits[N_PROG-1:0];
  assign data_bits = all_bits[N_PROG +: N_DATA];

  always_comb begin
    pen       = prog_bits[pidx];
    den       = data_bits[didx];
    reg_rdata = '0;
    for (int i = 0; i < N_REG; i++) begin
      if (reg_sel == SEL_W'(i)) reg_rdata = all_bits[i*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int REG_W      = 16,
  parameter int VOTE_W     = 3,
  parameter int PROG_LOG2  = 18,
  parameter int PSECT_LOG2 = 13,
  parameter int DATA_LOG2  = 13,
  parameter int DSECT_LOG2 = 9,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'h0E0000,
  parameter logic [ADDR_W-1:0] BOOT_MAX  = 24'h001BFF,
  localparam int N_PROG = 1 << (PROG_LOG2 - PSECT_LOG2),
  localparam int N_DATA = 1 << (DATA_LOG2 - DSECT_LOG2),
  localparam int N_REG  = (N_PROG + N_DATA) / REG_W,
  localparam int SEL_W  = $clog2(N_REG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_vld,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] boot_end,
  input  logic [VOTE_W-1:0] prot_wr,
  input  logic [VOTE_W-1:0] prot_rd,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ext_rd_req,
  input  logic [DATA_W-1:0] ext_rd_din,
  output logic              grant_vld,
  output logic              grant_we,
  output logic [ADDR_W-1:0] grant_addr,
  output logic [1:0]        grant_region,
  output logic              wr_viol,
  output logic              ext_rd_ack,
  output logic [DATA_W-1:0] ext_rd_dout,
  output logic              ext_rd_viol
);
  localparam int PS_W = PROG_LOG2 - PSECT_LOG2;
  localparam int DS_W = DATA_LOG2 - DSECT_LOG2;

  // reset synchronizer: asserts at once, releases on the second edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  region_e         region;
  logic            in_boot;
  logic [PS_W-1:0] psect;
  logic [DS_W-1:0] dsect;
  logic            pen, den;
  logic            wp_on, rp_on;

  fg_addr_decode #(
    .ADDR_W(ADDR_W), .PROG_LOG2(PROG_LOG2), .PSECT_LOG2(PSECT_LOG2),
    .DATA_LOG2(DATA_LOG2), .DSECT_LOG2(DSECT_LOG2),
    .DATA_BASE(DATA_BASE), .BOOT_MAX(BOOT_MAX)
  ) u_dec (
    .addr(cpu_addr), .boot_end(boot_end), .region(region),
    .in_boot(in_boot), .psect(psect), .dsect(dsect)
  );

  fg_sect_regs #(.REG_W(REG_W), .N_PROG(N_PROG), .N_DATA(N_DATA)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pidx(psect), .didx(dsect), .pen(pen), .den(den)
  );

  fg_vote #(.W(VOTE_W)) u_wvote (.bits(prot_wr), .active(wp_on));
  fg_vote #(.W(VOTE_W)) u_rvote (.bits(prot_rd), .active(rp_on));

  // next-state logic
  logic              sect_bit, wr_ok, allow;
  logic              gv_d, wv_d, ack_d, rv_d;
  logic [DATA_W-1:0] dout_d;

  always_comb begin
    sect_bit = (region == RGN_PROG) ? pen : den;
    wr_ok    = !in_boot && sect_bit && !wp_on;
    if (region == RGN_NONE) allow = 1'b1;
    else if (!cpu_we)       allow = 1'b1;
    else                    allow = wr_ok;
    gv_d   = cpu_vld && allow;
    wv_d   = cpu_vld && !allow;
    ack_d  = ext_rd_req;
    rv_d   = ext_rd_req && rp_on;
    dout_d = rp_on ? '0 : ext_rd_din;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_vld   <= 1'b0;
      wr_viol     <= 1'b0;
      ext_rd_ack  <= 1'b0;
      ext_rd_viol <= 1'b0;
    end else begin
      grant_vld   <= gv_d;
      wr_viol     <= wv_d;
      ext_rd_ack  <= ack_d;
      ext_rd_viol <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_we     <= 1'b0;
      grant_addr   <= '0;
      grant_region <= RGN_NONE;
    end else if (cpu_vld) begin
      grant_we     <= cpu_we;
      grant_addr   <= cpu_addr;
      grant_region <= region;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     ext_rd_dout <= '0;
    else if (ext_rd_req) ext_rd_dout <= dout_d;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int VOTE_W    = 3,
  parameter int PROG_LOG2 = 18,
  parameter logic [ADDR_W-1:0] DATA_BASE = 24'h0E0000,
  parameter int DATA_LOG2 = 13,
  parameter logic [ADDR_W-1:0] BOOT_MAX  = 24'h001BFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_vld,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [ADDR_W-1:0] boot_end,
  input logic [VOTE_W-1:0] prot_wr,
  input logic [VOTE_W-1:0] prot_rd,
  input logic              ext_rd_req,
  input logic              grant_vld,
  input logic              grant_we,
  input logic [ADDR_W-1:0] grant_addr,
  input logic [1:0]        grant_region,
  input logic              wr_viol,
  input logic [DATA_W-1:0] ext_rd_dout,
  input logic              ext_rd_viol
);
  logic armed;
  logic is_prog, is_flash, hits_boot;
  logic [ADDR_W-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    limit     = (boot_end < BOOT_MAX) ? boot_end : BOOT_MAX;
    is_prog   = (cpu_addr >> PROG_LOG2) == '0;
    is_flash  = is_prog || ((cpu_addr >> DATA_LOG2) == (DATA_BASE >> DATA_LOG2));
    hits_boot = is_prog && (cpu_addr <= limit);
  end

  p_boot_write_refused_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(cpu_vld && cpu_we && hits_boot) |-> (wr_viol && !grant_vld));

  p_global_write_lock_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(cpu_vld && cpu_we && is_flash && ($countones(~prot_wr) >= 2)) |-> wr_viol);

  p_cpu_read_granted_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(cpu_vld && !cpu_we) |-> (grant_vld && !grant_we));

  p_not_flash_pass_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(cpu_vld && !is_flash) |-> (grant_vld && grant_region == 2'd0 && !wr_viol));

  p_ext_read_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(ext_rd_req && ($countones(~prot_rd) >= 2)) |-> (ext_rd_viol && ext_rd_dout == '0));

  p_viol_excludes_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |-> !grant_vld);

  p_prog_region_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_region == 2'd1) |-> ((grant_addr >> PROG_LOG2) == '0));
endmodule

bind flash_guard fg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VOTE_W(VOTE_W), .PROG_LOG2(PROG_LOG2),
  .DATA_BASE(DATA_BASE), .DATA_LOG2(DATA_LOG2), .BOOT_MAX(BOOT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_vld(cpu_vld), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .boot_end(boot_end), .prot_wr(prot_wr), .prot_rd(prot_rd),
  .ext_rd_req(ext_rd_req), .grant_vld(grant_vld), .grant_we(grant_we),
  .grant_addr(grant_addr), .grant_region(grant_region), .wr_viol(wr_viol),
  .ext_rd_dout(ext_rd_dout), .ext_rd_viol(ext_rd_viol)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_vld, cpu_we;
  logic [23:0] cpu_addr, boot_end;
  logic [2:0]  prot_wr, prot_rd;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ext_rd_req;
  logic [15:0] ext_rd_din, ext_rd_dout;
  logic        grant_vld, grant_we, wr_viol, ext_rd_ack, ext_rd_viol;
  logic [23:0] grant_addr;
  logic [1:0]  grant_region;

  always #4 clk = ~clk;

  flash_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_vld(cpu_vld), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .boot_end(boot_end), .prot_wr(prot_wr), .prot_rd(prot_rd),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_rd_req(ext_rd_req), .ext_rd_din(ext_rd_din),
    .grant_vld(grant_vld), .grant_we(grant_we), .grant_addr(grant_addr),
    .grant_region(grant_region), .wr_viol(wr_viol), .ext_rd_ack(ext_rd_ack),
    .ext_rd_dout(ext_rd_dout), .ext_rd_viol(ext_rd_viol)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit after_reset = 1;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model
  int          rel_cnt;
  logic [15:0] m_reg [3];
  bit          e_gv, e_wv, e_ack, e_rv, e_we;
  int          e_addr, e_rgn;
  logic [15:0] e_dout;
  string       e_lbl;

  function automatic int rgn_of(int a);
    if (a < 'h40000) return 1;
    if (a >= 'hE0000 && a <= 'hE1FFF) return 2;
    return 0;
  endfunction

  function automatic bit majority_zero(logic [2:0] f);
    int z = 0;
    for (int i = 0; i < 3; i++) if (f[i] == 1'b0) z++;
    return z >= 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt = 0;
      for (int i = 0; i < 3; i++) m_reg[i] = '0;
      e_gv = 0; e_wv = 0; e_ack = 0; e_rv = 0; e_we = 0;
      e_addr = 0; e_rgn = 0; e_dout = '0; e_lbl = "R5";
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      int a, r, lim, s;
      bit en, ok;
      a = int'(cpu_addr);
      r = rgn_of(a);
      lim = (int'(boot_end) > 'h1BFF) ? 'h1BFF : int'(boot_end);
      if (r == 1) begin s = a / 8192; en = m_reg[s / 16][s % 16]; end
      else begin s = (a - 'hE0000) / 512; en = m_reg[2][s & 15]; end
      e_gv = 0; e_wv = 0;
      if (cpu_vld) begin
        e_we = cpu_we; e_addr = a; e_rgn = r;
        if (r == 0)                   begin ok = 1; e_lbl = "R11"; end
        else if (!cpu_we)             begin ok = 1; e_lbl = "R9"; end
        else if (r == 1 && a <= lim)  begin ok = 0; e_lbl = "R2/R3"; end
        else if (majority_zero(prot_wr)) begin ok = 0; e_lbl = "R7"; end
        else                          begin ok = en; e_lbl = "R6"; end
        e_gv = ok; e_wv = !ok;
      end
      e_ack = ext_rd_req;
      e_rv  = ext_rd_req && majority_zero(prot_rd);
      if (ext_rd_req) e_dout = majority_zero(prot_rd) ? 16'h0 : ext_rd_din;
      if (reg_wr && reg_sel < 3) m_reg[reg_sel] = reg_wdata;
    end
  end

  always @(posedge clk) begin
    cycles++;
    #2;
    if (!done) begin
      check(e_lbl, "grant_vld", grant_vld, e_gv);
      check("R10", "wr_viol", wr_viol, e_wv);
      if (e_gv) begin
        check("R10", "grant_addr", grant_addr, e_addr);
        check("R10", "grant_we", grant_we, e_we);
        check("R1", "grant_region", grant_region, e_rgn);
      end
      check("R8", "ext_rd_ack", ext_rd_ack, e_ack);
      check("R8", "ext_rd_viol", ext_rd_viol, e_rv);
      if (e_ack) check("R8", "ext_rd_dout", ext_rd_dout, e_dout);
      check(after_reset ? "R5" : "R4", "reg_rdata", reg_rdata,
            (reg_sel < 3) ? m_reg[reg_sel] : 16'h0);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [23:0] pick_addr();
    case ($urandom % 8)
      0: return 24'($urandom % 'h2400);
      1: return 24'($urandom % 'h40000);
      2: return 24'('h3FF00 + $urandom % 'h200);
      3: return 24'('hE0000 + $urandom % 'h2000);
      4: return 24'('hDFF00 + $urandom % 'h100);
      5: return 24'('hE1F00 + $urandom % 'h200);
      6: return 24'($urandom);
      default: return 24'('h1B00 + $urandom % 'h200);
    endcase
  endfunction

  initial begin
    rst_n = 0; cpu_vld = 0; cpu_we = 0; cpu_addr = 0; boot_end = 24'h0FFF;
    prot_wr = 3'b111; prot_rd = 3'b111; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    ext_rd_req = 0; ext_rd_din = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5: all registers read zero after reset, writes refused everywhere
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); reg_sel = 2'(i);
    end
    @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_addr = 24'h020000;
    @(negedge clk); cpu_addr = 24'h0E0200;
    @(negedge clk); cpu_vld = 0;
    @(negedge clk); after_reset = 0;
    // R4: enable all sections, then write to code 3 which must be ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); reg_wr = 1; reg_sel = 2'(i); reg_wdata = 16'hFFFF;
    end
    @(negedge clk); reg_wr = 0; reg_sel = 3;
    // R6 granted write outside boot; R3 boot write refused; R2 clamp
    @(negedge clk); cpu_vld = 1; cpu_we = 1; cpu_addr = 24'h001000;
    @(negedge clk); cpu_addr = 24'h000FFF;
    @(negedge clk); boot_end = 24'hFFFFFF; cpu_addr = 24'h001BFF;
    @(negedge clk); cpu_addr = 24'h001C00;
    @(negedge clk); prot_wr = 3'b010; cpu_addr = 24'h0E1FFE;
    @(negedge clk); prot_wr = 3'b011;
    @(negedge clk); cpu_we = 0; prot_wr = 3'b000; prot_rd = 3'b000; cpu_addr = 24'h000000;
    @(negedge clk); cpu_addr = 24'h0E2000; cpu_we = 1;
    @(negedge clk); cpu_vld = 0; ext_rd_req = 1; ext_rd_din = 16'hA5C3;
    @(negedge clk); prot_rd = 3'b101;
    @(negedge clk); prot_rd = 3'b110; ext_rd_din = 16'h1234;
    @(negedge clk); ext_rd_req = 0; reg_wr = 1; reg_sel = 0; reg_wdata = 16'h0004;
    @(negedge clk); reg_wr = 0; prot_wr = 3'b111; boot_end = 24'h0;
    cpu_vld = 1; cpu_we = 1; cpu_addr = 24'h004000;
    @(negedge clk); cpu_addr = 24'h006000;
    @(negedge clk); cpu_vld = 0;
    // random traffic
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      cpu_vld    = ($urandom % 4) != 0;
      cpu_we     = ($urandom % 3) != 0;
      cpu_addr   = pick_addr();
      boot_end   = ($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 'h1C00);
      prot_wr    = ($urandom % 2) ? 3'b111 : 3'($urandom);
      prot_rd    = 3'($urandom);
      reg_wr     = ($urandom % 6) == 0;
      reg_sel    = 2'($urandom);
      reg_wdata  = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      ext_rd_req = ($urandom % 3) == 0;
      ext_rd_din = 16'($urandom);
    end
    @(negedge clk); cpu_vld = 0; reg_wr = 0; ext_rd_req = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule